// File: doc/BRIEF.md
# Dual-Clock 36-bit FIFO with Programmable Almost Flags

This block moves 36-bit words from a write port to a read port. Each port runs on its own clock, and the two clocks may be unrelated or may be the same clock. A port moves a word on a rising edge of its clock only when its select input is low and its enable input is high. The pointers cross between the clock domains as Gray codes, each through a two-stage synchroniser. Each domain works out its own flags from its own pointer and the synchronised copy of the other pointer.

A static mode input sets the meaning of the two status outputs. In standard mode, `rd_avail` means the memory holds at least one word. A read edge then loads the oldest word onto `rd_data`. `wr_room` means the memory is not full. In fall-through mode, the oldest word is prefetched into the output register. `rd_avail` then means that `rd_data` already holds a valid word, and a read edge pops that word and loads the next one. Because of the prefetch, the FIFO holds one word more in this mode. The active-low almost-empty flag compares the word count with the `ofs_x` offset. The active-low almost-full flag compares the free memory locations with the `ofs_y` offset. Both offsets can be changed at run time.

Top module: `xfifo36`

## Requirements
- R1: A word is written only on a `wr_clk` rising edge with `wr_sel_n`=0, `wr_en`=1 and `wr_room`=1. A word is read only on a `rd_clk` rising edge with `rd_sel_n`=0, `rd_en`=1 and `rd_avail`=1. With `rd_sel_n`=1 or `rd_en`=0, `rd_data` and a high `rd_avail` are left unchanged.
- R2: `wr_room`=0 when all DEPTH memory locations are used. A write attempted while `wr_room`=0 is dropped. In standard mode the FIFO accepts exactly DEPTH words from empty. In fall-through mode it accepts DEPTH+1 words, the extra one sitting in the output register.
- R3: Words leave the FIFO in the order they were written, with every bit intact, whatever the ratio of the two clocks.
- R4: Standard mode (`mode_fwft`=0): once both sides have been idle for a few cycles, `rd_avail`=1 exactly when the FIFO holds one or more words. `rd_data` changes only on an accepted read edge, and it then shows the word that was popped.
- R5: Fall-through mode (`mode_fwft`=1): the oldest word appears on `rd_data` with `rd_avail`=1 without any read. An accepted read edge replaces it with the next word, or clears `rd_avail` if no word follows.
- R6: Once settled, `rd_aempty_n`=0 exactly when the word count is at most `ofs_x`. In fall-through mode the word count includes the word in the output register.
- R7: Once settled, `wr_afull_n`=0 exactly when the number of free memory locations (DEPTH minus the words in memory, not counting the output register) is at most `ofs_y`.
- R8: After reset, with each active-low reset sampled on its own clock: `wr_room`=1, `rd_avail`=0, `rd_aempty_n`=0, `wr_afull_n`=1 and `rd_data`=0.
- R9: Flags lag by at most three cycles of their own clock after the other side stops. The write-domain copy of the read pointer never lets the used count exceed DEPTH, and the read-domain copy never lets the read pointer pass the write pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side synchronous reset, active low |
| wr_sel_n | input | 1 | Write port select, active low |
| wr_en | input | 1 | Write enable, active high |
| wr_data | input | WIDTH | Word to write |
| wr_room | output | 1 | High when a write would be accepted (not full) |
| wr_afull_n | output | 1 | Almost-full flag, low when free locations are at most ofs_y |
| ofs_y | input | log2(DEPTH) | Almost-full offset |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Read-side synchronous reset, active low |
| rd_sel_n | input | 1 | Read port select, active low |
| rd_en | input | 1 | Read enable, active high |
| rd_data | output | WIDTH | Output word register |
| rd_avail | output | 1 | Standard: memory not empty. Fall-through: rd_data holds a valid word |
| rd_aempty_n | output | 1 | Almost-empty flag, low when the word count is at most ofs_x |
| ofs_x | input | log2(DEPTH) | Almost-empty offset |
| mode_fwft | input | 1 | 0 selects standard mode, 1 selects fall-through mode; held static |

## Verification
A corrupted pointer or a bad Gray crossing shows at the ports on the next read. A word comes out of order or altered, and this is seen on the first pop after the fault. A count that drifts shows up as wrong flags. Once both sides stop, `wr_room`, `rd_avail` and the two almost flags stop agreeing with the number of words written minus the number read, and the bench sees this within a dozen read-clock cycles of going idle. A lost prefetch in fall-through mode shows as `rd_avail` staying low, or as a stale word, while the bench model still holds data.

// File: rtl/xfifo_pkg.sv
// Shared definitions for the dual-clock FIFO.
// Assumes: the mode input is held static from reset onward.
package xfifo_pkg;
    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } xfifo_mode_e;
endpackage

// File: rtl/xfifo_gray2bin.sv
// Converts a Gray-coded pointer back to binary.
// Assumes: a plain combinational use, with any width of two bits or more.
module xfifo_gray2bin #(
    parameter int PW = 9
) (
    input  logic [PW-1:0] gray,
    output logic [PW-1:0] bin
);
    // Prefix XOR, starting from the most significant bit.
    always_comb begin
        bin = gray;
        for (int i = PW - 2; i >= 0; i--) begin
            bin[i] = bin[i+1] ^ gray[i];
        end
    end
endmodule

// File: rtl/xfifo_sync.sv
// Two-stage synchroniser for a Gray-coded pointer.
// Assumes: the input changes by at most one bit per source clock.
module xfifo_sync #(
    parameter int PW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] d,
    output logic [PW-1:0] q
);
    logic [PW-1:0] meta;

    // Two flops in the destination domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/xfifo_ram.sv
// Simple dual-port storage: write on the write clock, registered read on the read clock.
// Assumes: never read at a location that is being written in the same period.
module xfifo_ram #(
    parameter int WIDTH = 36,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             wr_clk,
    input  logic             wr_we,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_d,
    input  logic             rd_clk,
    input  logic             rd_rst_n,
    input  logic             rd_re,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_q
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Store the word on an accepted write.
    always_ff @(posedge wr_clk) begin
        if (wr_we) begin
            mem[wr_addr] <= wr_d;
        end
    end

    // Load the output register on a fetch.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            rd_q <= '0;
        end else if (rd_re) begin
            rd_q <= mem[rd_addr];
        end
    end
endmodule

// File: rtl/xfifo_wr.sv
// Write-side control: write pointer, not-full flag and almost-full flag.
// Assumes: rgray_s is the read pointer after synchronisation into this domain.
module xfifo_wr #(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_n,
    input  logic          en,
    input  logic [AW-1:0] ofs_y,
    input  logic [PW-1:0] rgray_s,
    output logic          push,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wgray,
    output logic [PW-1:0] wptr,
    output logic [PW-1:0] rptr_s,
    output logic          room,
    output logic          afull_n
);
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    logic          full_q;
    logic [PW-1:0] wnx, used_nx, free_nx;

    xfifo_gray2bin #(.PW(PW)) u_rconv (.gray(rgray_s), .bin(rptr_s));

    // Accept a write and work out the flags for the next cycle.
    always_comb begin
        push    = en && !sel_n && !full_q;
        wnx     = wptr + {{(PW-1){1'b0}}, push};
        used_nx = wnx - rptr_s;
        free_nx = DEPTH_P - used_nx;
    end

    // Pointer, Gray copy and registered flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr    <= '0;
            wgray   <= '0;
            full_q  <= 1'b0;
            afull_n <= 1'b1;
        end else begin
            wptr    <= wnx;
            wgray   <= wnx ^ (wnx >> 1);
            full_q  <= (used_nx == DEPTH_P);
            afull_n <= !(free_nx <= {1'b0, ofs_y});
        end
    end

    assign waddr = wptr[AW-1:0];
    assign room  = !full_q;
endmodule

// File: rtl/xfifo_rd.sv
// Read-side control: read pointer, memory-empty state, prefetch register valid, almost-empty flag.
// Assumes: wgray_s is the write pointer after synchronisation; fwft is static.
module xfifo_rd #(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fwft,
    input  logic          sel_n,
    input  logic          en,
    input  logic [AW-1:0] ofs_x,
    input  logic [PW-1:0] wgray_s,
    output logic          fetch,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] rgray,
    output logic [PW-1:0] rptr,
    output logic [PW-1:0] wptr_s,
    output logic          avail,
    output logic          aempty_n
);
    logic          empty_q, ov_q, user_rd, ov_nx;
    logic [PW-1:0] rnx, mem_nx, cnt_nx;

    xfifo_gray2bin #(.PW(PW)) u_wconv (.gray(wgray_s), .bin(wptr_s));

    // Decide the user pop, the memory fetch and the next-cycle counts.
    always_comb begin
        user_rd = en && !sel_n && (fwft ? ov_q : !empty_q);
        fetch   = fwft ? (!empty_q && (!ov_q || user_rd)) : user_rd;
        rnx     = rptr + {{(PW-1){1'b0}}, fetch};
        mem_nx  = wptr_s - rnx;
        if (!fwft)        ov_nx = 1'b0;
        else if (fetch)   ov_nx = 1'b1;
        else if (user_rd) ov_nx = 1'b0;
        else              ov_nx = ov_q;
        cnt_nx  = mem_nx + {{(PW-1){1'b0}}, ov_nx};
    end

    // Pointer, Gray copy and registered flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr     <= '0;
            rgray    <= '0;
            empty_q  <= 1'b1;
            ov_q     <= 1'b0;
            aempty_n <= 1'b0;
        end else begin
            rptr     <= rnx;
            rgray    <= rnx ^ (rnx >> 1);
            empty_q  <= (mem_nx == '0);
            ov_q     <= ov_nx;
            aempty_n <= !(cnt_nx <= {1'b0, ofs_x});
        end
    end

    assign raddr = rptr[AW-1:0];
    assign avail = fwft ? ov_q : !empty_q;
endmodule

// File: rtl/xfifo36.sv
// Top level of the dual-clock FIFO: storage, write and read control, pointer crossings.
// Assumes: each reset is held long enough to be seen on its own clock; mode_fwft is static.
module xfifo36 #(
    parameter int WIDTH = 36,
    parameter int DEPTH = 256
) (
    input  logic                     wr_clk,
    input  logic                     wr_rst_n,
    input  logic                     wr_sel_n,
    input  logic                     wr_en,
    input  logic [WIDTH-1:0]         wr_data,
    output logic                     wr_room,
    output logic                     wr_afull_n,
    input  logic [$clog2(DEPTH)-1:0] ofs_y,
    input  logic                     rd_clk,
    input  logic                     rd_rst_n,
    input  logic                     rd_sel_n,
    input  logic                     rd_en,
    output logic [WIDTH-1:0]         rd_data,
    output logic                     rd_avail,
    output logic                     rd_aempty_n,
    input  logic [$clog2(DEPTH)-1:0] ofs_x,
    input  logic                     mode_fwft
);
    import xfifo_pkg::*;

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic          push, fetch, fwft;
    logic [AW-1:0] waddr, raddr;
    logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
    logic [PW-1:0] wptr, rptr, wptr_s, rptr_s;

    assign fwft = (xfifo_mode_e'(mode_fwft) == MODE_FWFT);

    xfifo_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
        .wr_clk(wr_clk), .wr_we(push), .wr_addr(waddr), .wr_d(wr_data),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_re(fetch), .rd_addr(raddr),
        .rd_q(rd_data)
    );

    xfifo_wr #(.DEPTH(DEPTH)) u_wr (
        .clk(wr_clk), .rst_n(wr_rst_n), .sel_n(wr_sel_n), .en(wr_en),
        .ofs_y(ofs_y), .rgray_s(rgray_s), .push(push), .waddr(waddr),
        .wgray(wgray), .wptr(wptr), .rptr_s(rptr_s), .room(wr_room),
        .afull_n(wr_afull_n)
    );

    xfifo_rd #(.DEPTH(DEPTH)) u_rd (
        .clk(rd_clk), .rst_n(rd_rst_n), .fwft(fwft), .sel_n(rd_sel_n),
        .en(rd_en), .ofs_x(ofs_x), .wgray_s(wgray_s), .fetch(fetch),
        .raddr(raddr), .rgray(rgray), .rptr(rptr), .wptr_s(wptr_s),
        .avail(rd_avail), .aempty_n(rd_aempty_n)
    );

    xfifo_sync #(.PW(PW)) u_w2r (.clk(rd_clk), .rst_n(rd_rst_n), .d(wgray), .q(wgray_s));
    xfifo_sync #(.PW(PW)) u_r2w (.clk(wr_clk), .rst_n(wr_rst_n), .d(rgray), .q(rgray_s));
endmodule

// File: rtl/xfifo36_chk.sv
// Assertion checker for xfifo36, attached with bind.
// Assumes: it observes pointers and ports only and drives nothing.
module xfifo36_chk #(
    parameter int WIDTH = 36,
    parameter int PW    = 9,
    parameter int DEPTH = 256
) (
    input logic             wr_clk,
    input logic             wr_rst_n,
    input logic             rd_clk,
    input logic             rd_rst_n,
    input logic             fwft,
    input logic             wr_room,
    input logic [PW-1:0]    wptr,
    input logic [PW-1:0]    wgray,
    input logic [PW-1:0]    rptr_s,
    input logic [PW-1:0]    rptr,
    input logic [PW-1:0]    wptr_s,
    input logic             rd_sel_n,
    input logic             rd_en,
    input logic             rd_avail,
    input logic [WIDTH-1:0] rd_data
);
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    // R2: the used count seen by the write side never exceeds DEPTH.
    a_r2_no_overflow: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wptr - rptr_s) <= DEPTH_P);

    // R2: with no room, the write pointer does not advance.
    a_r2_hold_when_full: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        !wr_room |=> $stable(wptr));

    // R9: the read pointer never passes the synchronised write pointer.
    a_r9_no_underflow: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (wptr_s - rptr) <= DEPTH_P);

    // R9: the Gray pointer sent across changes by at most one bit per cycle.
    a_r9_gray_step: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);

    // R4: in standard mode, the output word holds when no read is accepted.
    a_r4_std_hold: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (!fwft && !(rd_en && !rd_sel_n && rd_avail)) |=> $stable(rd_data));

    // R5: in fall-through mode, a presented word stays until it is popped.
    a_r5_fwft_hold: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (fwft && rd_avail && !(rd_en && !rd_sel_n)) |=> (rd_avail && $stable(rd_data)));
endmodule

bind xfifo36 xfifo36_chk #(.WIDTH(WIDTH), .PW(PW), .DEPTH(DEPTH)) u_chk (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
    .fwft(fwft), .wr_room(wr_room), .wptr(wptr), .wgray(wgray), .rptr_s(rptr_s),
    .rptr(rptr), .wptr_s(wptr_s), .rd_sel_n(rd_sel_n), .rd_en(rd_en),
    .rd_avail(rd_avail), .rd_data(rd_data)
);

// File: tb/xfifo36_tb.sv
`timescale 1ns/1ps
// Self-checking bench for xfifo36: directed fill and drain in both modes, then random traffic.
module xfifo36_tb;
    localparam int WIDTH = 36;
    localparam int DEPTH = 256;
    localparam int AW    = $clog2(DEPTH);

    logic             wr_clk = 1'b0, rd_clk = 1'b0;
    logic             wr_rst_n = 1'b0, rd_rst_n = 1'b0;
    logic             wr_sel_n = 1'b1, wr_en = 1'b0;
    logic [WIDTH-1:0] wr_data = '0;
    logic             rd_sel_n = 1'b1, rd_en = 1'b0;
    logic [AW-1:0]    ofs_x = AW'(8), ofs_y = AW'(16);
    logic             mode_fwft = 1'b0;
    logic             wr_room, wr_afull_n, rd_avail, rd_aempty_n;
    logic [WIDTH-1:0] rd_data;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [WIDTH-1:0] q[$];

    always #2.0 wr_clk = ~wr_clk;
    always #3.5 rd_clk = ~rd_clk;

    xfifo36 #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_dut (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_sel_n(wr_sel_n), .wr_en(wr_en),
        .wr_data(wr_data), .wr_room(wr_room), .wr_afull_n(wr_afull_n), .ofs_y(ofs_y),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_sel_n(rd_sel_n), .rd_en(rd_en),
        .rd_data(rd_data), .rd_avail(rd_avail), .rd_aempty_n(rd_aempty_n),
        .ofs_x(ofs_x), .mode_fwft(mode_fwft)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int mem_words(input int cnt, input bit fw);
        return (fw && cnt > 0) ? cnt - 1 : cnt;
    endfunction

    task automatic do_reset(input bit fw);
        @(negedge wr_clk);
        wr_rst_n = 1'b0; rd_rst_n = 1'b0; mode_fwft = fw;
        wr_en = 1'b0; wr_sel_n = 1'b1; rd_en = 1'b0; rd_sel_n = 1'b1;
        repeat (6) @(negedge rd_clk);
        rd_rst_n = 1'b1;
        @(negedge wr_clk);
        wr_rst_n = 1'b1;
        q.delete();
        @(negedge rd_clk);
        // R8: state after reset
        chk(wr_room == 1'b1, "R8", "wr_room", wr_room, 1);
        chk(rd_avail == 1'b0, "R8", "rd_avail", rd_avail, 0);
        chk(rd_aempty_n == 1'b0, "R8", "rd_aempty_n", rd_aempty_n, 0);
        chk(wr_afull_n == 1'b1, "R8", "wr_afull_n", wr_afull_n, 1);
        chk(rd_data == '0, "R8", "rd_data", rd_data, 0);
    endtask

    // Write attempt; returns whether the bench expects it accepted (R1, R2).
    task automatic wr_op(input bit sel_n, input bit en, input logic [WIDTH-1:0] d,
                         output bit took);
        bit room;
        @(negedge wr_clk);
        room = wr_room;
        wr_sel_n = sel_n; wr_en = en; wr_data = d;
        @(posedge wr_clk);
        #1;
        wr_sel_n = 1'b1; wr_en = 1'b0;
        took = en && !sel_n && room;
        if (took) q.push_back(d);
    endtask

    // Read attempt with checks of order (R3) and hold behaviour (R1, R4, R5).
    task automatic rd_op(input bit sel_n, input bit en);
        bit av, took;
        logic [WIDTH-1:0] old, expw;
        @(negedge rd_clk);
        av = rd_avail; old = rd_data;
        if (mode_fwft && av) begin
            if (q.size() == 0) chk(1'b0, "R5", "valid with empty model", 1, 0);
            else chk(rd_data == q[0], "R5", "presented word", rd_data, q[0]);
        end
        rd_sel_n = sel_n; rd_en = en;
        @(posedge rd_clk);
        #1;
        rd_sel_n = 1'b1; rd_en = 1'b0;
        took = en && !sel_n && av;
        if (took) begin
            if (q.size() == 0) begin
                chk(1'b0, "R3", "pop from empty model", 1, 0);
                return;
            end
            expw = q.pop_front();
        end
        @(negedge rd_clk);
        if (!mode_fwft) begin
            if (took) chk(rd_data == expw, "R3", "read order", rd_data, expw);
            else      chk(rd_data == old, "R1", "rd_data held", rd_data, old);
        end else if (!took && av) begin
            chk(rd_avail == 1'b1, "R1", "rd_avail held", rd_avail, 1);
            chk(rd_data == old, "R1", "fwft word held", rd_data, old);
        end
    endtask

    // Idle both sides, then compare every flag with the model (R2, R4-R7, R9).
    task automatic settle_check();
        int cnt, mw;
        repeat (12) @(negedge rd_clk);
        cnt = q.size();
        mw  = mem_words(cnt, mode_fwft);
        if (mode_fwft) begin
            chk(rd_avail == (cnt > 0), "R5", "rd_avail settled", rd_avail, cnt > 0);
            if (cnt > 0) chk(rd_data == q[0], "R5", "head word", rd_data, q[0]);
        end else begin
            chk(rd_avail == (cnt > 0), "R4", "rd_avail settled", rd_avail, cnt > 0);
        end
        chk(wr_room == (mw < DEPTH), "R2", "wr_room settled", wr_room, mw < DEPTH);
        chk(rd_aempty_n == !(cnt <= int'(ofs_x)), "R6", "rd_aempty_n",
            rd_aempty_n, !(cnt <= int'(ofs_x)));
        chk(wr_afull_n == !((DEPTH - mw) <= int'(ofs_y)), "R7", "wr_afull_n",
            wr_afull_n, !((DEPTH - mw) <= int'(ofs_y)));
    endtask

    task automatic run_mode(input bit fw);
        bit took;
        int acc;
        ofs_x = AW'(8); ofs_y = AW'(16);
        do_reset(fw);
        // R2: directed fill until the write is refused, flags checked at each level.
        acc = 0;
        for (int i = 0; i < DEPTH + 3; i++) begin
            wr_op(1'b0, 1'b1, {$urandom, 4'(i)}, took);
            if (took) acc++;
            settle_check();
        end
        chk(acc == (fw ? DEPTH + 1 : DEPTH), "R2", "words accepted from empty",
            acc, fw ? DEPTH + 1 : DEPTH);
        // R1: writes with the select high or the enable low are ignored.
        wr_op(1'b1, 1'b1, '1, took);
        wr_op(1'b0, 1'b0, '1, took);
        // R3: drain, checking order and flags at each level.
        while (q.size() > 0) begin
            rd_op(1'b0, 1'b1);
            settle_check();
        end
        rd_op(1'b0, 1'b1);  // R1: read from empty leaves the output alone
        // R1 / R3: random traffic with random offsets and masked strobes.
        ofs_x = AW'($urandom % DEPTH); ofs_y = AW'($urandom % DEPTH);
        for (int n = 0; n < 1500; n++) begin
            int r;
            r = int'($urandom % 10);
            if (r < 5)      wr_op(($urandom % 8) == 0, ($urandom % 8) != 0,
                                  {$urandom, 4'($urandom)}, took);
            else if (r < 9) rd_op(($urandom % 8) == 0, ($urandom % 8) != 0);
            else            settle_check();
        end
        while (q.size() > 0) rd_op(1'b0, 1'b1);
        settle_check();
    endtask

    initial begin
        void'($urandom(32'd1234));
        run_mode(1'b0);
        run_mode(1'b1);
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (190000) @(posedge wr_clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule